// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address to a real address by searching a hashed page table held in memory. It is started once the segment stage has produced the virtual segment identifier and a permission result for the access. From the segment identifier and the page index taken from the effective address it forms a hash and a compare tag. It then reads the eight two-word entries of the primary group one at a time. If none matches, it repeats the search in a secondary group located by the one's complement of the hash.

Memory is reached through a single request/response port. A request is held with a stable address until the response strobe arrives. On a hit the walker sets the referenced and changed status bits of the entry with single-byte stores where needed. It then returns the real page number joined with the page offset, together with the incoming permission adjusted for the changed bit. When neither group holds a match it reports a miss and is ready for the next request on the following cycle.

Top module: `hpt_walker`

## Requirements
- R1: The page index is effective-address bits 27:12. The hash is the segment identifier XOR the page index, kept to 19 bits. The first group searched starts at byte address `tbl_base | ((hash & {tbl_mask, 10'h3FF}) << 6)`, and entry n of a group is at group address + 8n.
- R2: Word 0 of an entry matches only when all of the following hold: bit 31 (valid) is set, bit 6 (pass bit) equals the current pass (0 first, 1 second), bits 30:7 equal the segment identifier, and bits 5:0 equal page-index bits 15:10. Entries that fail any of these are skipped.
- R3: After the eight entries of the first group fail, the same search runs over the group located by the bitwise complement of the 19-bit hash, with the same mask and base.
- R4: Word 1 (entry offset 4) of an entry is read only after word 0 of that same entry has been read and matched.
- R5: On a hit whose word 1 has bit 8 (referenced) clear, the walker stores one byte at entry offset 6 (memory is big-endian) with the value word1[15:8] | 0x01.
- R6: On a hit by a store access (`req_kind` = 1) whose word 1 has bit 7 (changed) clear, the walker stores one byte at entry offset 7 with the value word1[7:0] | 0x80. This store follows any store made under R5.
- R7: On a hit by a load (`req_kind` = 0) or a fetch (`req_kind` = 2) whose changed bit is clear, the returned permission is `req_prot` with the write bit (bit 1) cleared, and the changed bit in memory stays clear. In every other hit `res_prot` equals `req_prot`. Permission bits are bit 0 read, bit 1 write and bit 2 execute.
- R8: The real address is word1[31:12] joined with effective-address bits 11:0.
- R9: When sixteen entries fail, `done` is raised with `res_miss` set and `res_hit` clear. On a hit `res_hit` is set and `res_miss` is clear. `done` lasts one cycle, and `req_ready` is high on the next cycle.
- R10: After reset the walker is idle: `req_ready` is high, and `mem_req` and `done` are low.
- R11: With a memory that answers each request on the following cycle, `done` is high exactly 2·A+1 cycles after the accepting clock edge, where A is the total number of reads and byte stores made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when `req_ready` is high) |
| req_ready | output | 1 | Walker idle |
| req_vsid | input | 24 | Segment identifier from the segment stage |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_prot | input | 3 | Permission result {exec, write, read} |
| tbl_base | input | 32 | Table base byte address |
| tbl_mask | input | 9 | Mask on hash bits 18:10 |
| mem_req | output | 1 | Memory request, held until `mem_rvalid` |
| mem_we | output | 1 | Request is a byte store |
| mem_addr | output | 32 | Byte address of the request |
| mem_wbyte | output | 8 | Byte written by a store |
| mem_rvalid | input | 1 | Response strobe for the pending request |
| mem_rdata | input | 32 | Read word |
| done | output | 1 | Result valid for one cycle |
| res_hit | output | 1 | Entry found |
| res_miss | output | 1 | No entry in either group |
| res_raddr | output | 32 | Real address |
| res_prot | output | 3 | Adjusted permission |

## Verification
Every access takes two cycles against a memory that replies one cycle after it sees the request. The result is therefore due at a cycle fixed by the number of reads and byte stores, which depends on the slot, the group, and the state of the referenced and changed bits. For each vector the bench computes that count from the requirements. It counts cycles from the accepting edge at the falling edge and checks that `done` appears at exactly 2·A+1. It samples the result flags, address and permission in that same cycle. The table contents, including the updated status byte, are read back only after `done`.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [2:0] PROT_WR = 3'b010;

  localparam int PAGE_SHIFT = 12;
  localparam int PGIDX_W    = 16;
  localparam int API_W      = 6;
  localparam int REF_BIT    = 8;
  localparam int CHG_BIT    = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_WRR,
    ST_WRC,
    ST_FIN
  } walk_st_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash import hpt_pkg::*; #(
  parameter int AW        = 32,
  parameter int VSID_W    = 24,
  parameter int HASH_W    = 19,
  parameter int MASK_W    = 9,
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [AW-1:0]     ea,
  input  logic [AW-1:0]     base,
  input  logic [MASK_W-1:0] mask,
  input  logic              pass,
  output logic [AW-1:0]     grp_addr,
  output logic [API_W-1:0]  api
);
  localparam int LOW_W = HASH_W - MASK_W;

  logic [PGIDX_W-1:0] pgidx;
  logic [VSID_W-1:0]  hash_full;
  logic [HASH_W-1:0]  hash_sel;
  logic [HASH_W-1:0]  hash_msk;

  always_comb begin
    pgidx     = ea[PAGE_SHIFT +: PGIDX_W];
    hash_full = vsid ^ VSID_W'(pgidx);
    hash_sel  = pass ? ~hash_full[HASH_W-1:0] : hash_full[HASH_W-1:0];
    hash_msk  = hash_sel & {mask, {LOW_W{1'b1}}};
    grp_addr  = base | (AW'(hash_msk) << GRP_SHIFT);
    api       = pgidx[PGIDX_W-1 -: API_W];
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match import hpt_pkg::*; #(
  parameter int VSID_W = 24
) (
  input  logic [31:0]       word0,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              pass,
  output logic              match
);
  localparam int VSID_LSB = API_W + 1;

  logic valid_ok, pass_ok, tag_ok;

  always_comb begin
    valid_ok = word0[31];
    pass_ok  = (word0[API_W] == pass);
    tag_ok   = (word0[VSID_LSB +: VSID_W] == vsid) && (word0[API_W-1:0] == api);
    match    = valid_ok && pass_ok && tag_ok;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker import hpt_pkg::*; #(
  parameter int AW      = 32,
  parameter int VSID_W  = 24,
  parameter int MASK_W  = 9,
  parameter int HASH_W  = 19,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VSID_W-1:0] req_vsid,
  input  logic [AW-1:0]     req_ea,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_prot,
  input  logic [AW-1:0]     tbl_base,
  input  logic [MASK_W-1:0] tbl_mask,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wbyte,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              res_hit,
  output logic              res_miss,
  output logic [AW-1:0]     res_raddr,
  output logic [2:0]        res_prot
);
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int ENT_SHIFT = 3;
  localparam int GRP_SHIFT = IDX_W + ENT_SHIFT;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  walk_st_t          st;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VSID_W-1:0] vsid_q;
  logic [AW-1:0]     ea_q;
  logic [1:0]        kind_q;
  logic [2:0]        prot_q;
  logic [AW-1:0]     base_q;
  logic [MASK_W-1:0] mask_q;
  logic [31:0]       w1_q;

  logic [AW-1:0]     grp_addr;
  logic [API_W-1:0]  api;
  logic              w0_match;
  logic [AW-1:0]     entry_addr;
  logic [31:0]       fin_w1;
  logic [2:0]        fin_prot;
  logic [AW-1:0]     fin_raddr;
  logic              is_store;

  hpt_hash #(
    .AW(AW), .VSID_W(VSID_W), .HASH_W(HASH_W), .MASK_W(MASK_W), .GRP_SHIFT(GRP_SHIFT)
  ) u_hash (
    .vsid(vsid_q), .ea(ea_q), .base(base_q), .mask(mask_q), .pass(pass_q),
    .grp_addr(grp_addr), .api(api)
  );

  hpt_match #(.VSID_W(VSID_W)) u_match (
    .word0(mem_rdata), .vsid(vsid_q), .api(api), .pass(pass_q), .match(w0_match)
  );

  always_comb begin
    entry_addr = grp_addr | AW'({idx_q, {ENT_SHIFT{1'b0}}});
    is_store   = (kind_q == KIND_STORE);
    fin_w1     = (st == ST_RD1) ? mem_rdata : w1_q;
    fin_prot   = prot_q & ~((!fin_w1[CHG_BIT] && !is_store) ? PROT_WR : 3'b000);
    fin_raddr  = {fin_w1[31:PAGE_SHIFT], ea_q[PAGE_SHIFT-1:0]};
    req_ready  = (st == ST_IDLE);
    mem_req    = (st == ST_RD0) || (st == ST_RD1) || (st == ST_WRR) || (st == ST_WRC);
    mem_we     = (st == ST_WRR) || (st == ST_WRC);
    mem_addr   = entry_addr;
    mem_wbyte  = 8'h00;
    case (st)
      ST_RD1: mem_addr = entry_addr | AW'(4);
      ST_WRR: begin
        mem_addr  = entry_addr | AW'(6);
        mem_wbyte = w1_q[15:8] | 8'h01;
      end
      ST_WRC: begin
        mem_addr  = entry_addr | AW'(7);
        mem_wbyte = w1_q[7:0] | 8'h80;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pass_q    <= 1'b0;
      idx_q     <= '0;
      vsid_q    <= '0;
      ea_q      <= '0;
      kind_q    <= KIND_LOAD;
      prot_q    <= '0;
      base_q    <= '0;
      mask_q    <= '0;
      w1_q      <= '0;
      done      <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_raddr <= '0;
      res_prot  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vsid_q <= req_vsid;
            ea_q   <= req_ea;
            kind_q <= req_kind;
            prot_q <= req_prot;
            base_q <= tbl_base;
            mask_q <= tbl_mask;
            pass_q <= 1'b0;
            idx_q  <= '0;
            st     <= ST_RD0;
          end
        end
        ST_RD0: begin
          if (mem_rvalid) begin
            if (w0_match) begin
              st <= ST_RD1;
            end else if (idx_q != LAST_IDX) begin
              idx_q <= idx_q + 1'b1;
            end else if (!pass_q) begin
              pass_q <= 1'b1;
              idx_q  <= '0;
            end else begin
              res_hit  <= 1'b0;
              res_miss <= 1'b1;
              done     <= 1'b1;
              st       <= ST_FIN;
            end
          end
        end
        ST_RD1: begin
          if (mem_rvalid) begin
            w1_q <= mem_rdata;
            if (!mem_rdata[REF_BIT]) begin
              st <= ST_WRR;
            end else if (!mem_rdata[CHG_BIT] && is_store) begin
              st <= ST_WRC;
            end else begin
              res_hit   <= 1'b1;
              res_miss  <= 1'b0;
              res_raddr <= fin_raddr;
              res_prot  <= fin_prot;
              done      <= 1'b1;
              st        <= ST_FIN;
            end
          end
        end
        ST_WRR: begin
          if (mem_rvalid) begin
            if (!w1_q[CHG_BIT] && is_store) begin
              st <= ST_WRC;
            end else begin
              res_hit   <= 1'b1;
              res_miss  <= 1'b0;
              res_raddr <= fin_raddr;
              res_prot  <= fin_prot;
              done      <= 1'b1;
              st        <= ST_FIN;
            end
          end
        end
        ST_WRC: begin
          if (mem_rvalid) begin
            res_hit   <= 1'b1;
            res_miss  <= 1'b0;
            res_raddr <= fin_raddr;
            res_prot  <= fin_prot;
            done      <= 1'b1;
            st        <= ST_FIN;
          end
        end
        ST_FIN: begin
          done <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R11
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_hit != res_miss)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready)); // R9
  AST_WR_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[2:1] == 2'b11)); // R5
  AST_CHG_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr[0]) |-> (kind_q == KIND_STORE)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req && !done)); // R10
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  localparam logic [31:0] BASE = 32'h0200_0000;

  typedef struct packed {
    logic [23:0] vsid;
    logic [31:0] ea;
    logic [1:0]  kind;
    logic [2:0]  prot;
    logic [8:0]  mask;
    logic [1:0]  where;   // 0 first group, 1 second group, 2 absent
    logic [2:0]  slot;
    logic [1:0]  decoy;   // 0 none, 1 invalid, 2 wrong pass bit, 3 wrong tag
    logic [19:0] rpn;
    logic        rbit;
    logic        cbit;
    logic [2:0]  exp_prot;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{24'h000123, 32'h1234_5678, 2'd0, 3'd3, 9'h000, 2'd0, 3'd0, 2'd0, 20'hABCDE, 1'b1, 1'b1, 3'd3},
    '{24'h0ABCDE, 32'h0FFF_F004, 2'd1, 3'd3, 9'h000, 2'd0, 3'd7, 2'd0, 20'h00042, 1'b0, 1'b0, 3'd3},
    '{24'h000777, 32'h3000_1ABC, 2'd0, 3'd3, 9'h000, 2'd1, 3'd2, 2'd2, 20'h55555, 1'b0, 1'b0, 3'd1},
    '{24'h123456, 32'hF00D_0FFF, 2'd2, 3'd5, 9'h1FF, 2'd1, 3'd0, 2'd1, 20'hFFFFF, 1'b1, 1'b0, 3'd5},
    '{24'h00F0F0, 32'h0000_0000, 2'd0, 3'd3, 9'h0A5, 2'd2, 3'd0, 2'd2, 20'h00000, 1'b1, 1'b1, 3'd0},
    '{24'hFEDCBA, 32'h7654_3210, 2'd1, 3'd3, 9'h1FF, 2'd0, 3'd3, 2'd3, 20'h13579, 1'b1, 1'b0, 3'd3},
    '{24'h000001, 32'h0000_1000, 2'd2, 3'd7, 9'h003, 2'd0, 3'd1, 2'd3, 20'h00001, 1'b0, 1'b1, 3'd7},
    '{24'h2468AC, 32'hABCD_EFFF, 2'd0, 3'd1, 9'h1FF, 2'd2, 3'd0, 2'd3, 20'h00000, 1'b0, 1'b0, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_vsid = '0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_prot = '0;
  logic [31:0] tbl_base = BASE;
  logic [8:0]  tbl_mask = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wbyte;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, res_hit, res_miss;
  logic [31:0] res_raddr;
  logic [2:0]  res_prot;

  int nchk = 0;
  int nfail = 0;
  int order_err = 0;
  logic [31:0] last_rd = '1;
  logic [31:0] mem [logic [31:0]];

  always #10 clk = ~clk;

  hpt_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vsid(req_vsid), .req_ea(req_ea), .req_kind(req_kind), .req_prot(req_prot),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wbyte(mem_wbyte),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .res_hit(res_hit), .res_miss(res_miss),
    .res_raddr(res_raddr), .res_prot(res_prot)
  );

  function automatic logic [31:0] rdw(input logic [31:0] a);
    logic [31:0] wa = {a[31:2], 2'b00};
    return mem.exists(wa) ? mem[wa] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
    end else if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      if (mem_we) begin
        logic [31:0] w;
        w = rdw(mem_addr);
        w[8*(3-int'(mem_addr[1:0])) +: 8] = mem_wbyte;
        mem[{mem_addr[31:2], 2'b00}] = w;
      end else begin
        mem_rdata <= rdw(mem_addr);
        if (mem_addr[2] && (last_rd != (mem_addr - 32'd4))) order_err++;
        last_rd = mem_addr;
      end
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  function automatic logic [31:0] grp(input logic [23:0] vs, input logic [31:0] ea,
                                      input logic [8:0] m, input bit sec);
    logic [23:0] h = vs ^ {8'h00, ea[27:12]};
    logic [18:0] hs = sec ? ~h[18:0] : h[18:0];
    return BASE | ({13'h0, hs & {m, 10'h3FF}} << 6);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: idle after reset
    chk(req_ready === 1'b1, "R10 ready", {31'h0, req_ready}, 32'd1);
    chk(mem_req === 1'b0, "R10 mem_req", {31'h0, mem_req}, 32'd0);
    chk(done === 1'b0, "R10 done", {31'h0, done}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VEC[v];
      logic [31:0] w0, w1, ea_e, w1_exp, w1_addr;
      logic [5:0] apiv;
      int reads, writes, n;
      bit hit;
      mem.delete();
      last_rd = '1;
      order_err = 0;
      apiv = t.ea[27:22];
      w0 = {1'b1, t.vsid, 1'b0, apiv};
      w1 = {t.rpn, 3'b000, t.rbit, t.cbit, 7'h02};
      if (t.decoy != 0) begin
        logic [31:0] d = w0;
        if (t.decoy == 1) d[31] = 1'b0;
        if (t.decoy == 2) d[6] = 1'b1;
        if (t.decoy == 3) d[0] = ~d[0];
        mem[grp(t.vsid, t.ea, t.mask, 1'b0)] = d;
        mem[grp(t.vsid, t.ea, t.mask, 1'b0) + 32'd4] = w1;
      end
      hit = (t.where != 2);
      ea_e = grp(t.vsid, t.ea, t.mask, t.where == 1) + {26'h0, t.slot, 3'b000};
      w1_addr = ea_e + 32'd4;
      if (hit) begin
        if (t.where == 1) w0[6] = 1'b1;
        mem[ea_e] = w0;
        mem[w1_addr] = w1;
      end
      reads  = (t.where == 0) ? int'(t.slot) + 2 : (t.where == 1) ? 8 + int'(t.slot) + 2 : 16;
      writes = hit ? ((t.rbit ? 0 : 1) + ((!t.cbit && t.kind == 2'd1) ? 1 : 0)) : 0;
      w1_exp = w1 | 32'h100 | ((t.kind == 2'd1) ? 32'h80 : 32'h0);

      req_vsid = t.vsid; req_ea = t.ea; req_kind = t.kind; req_prot = t.prot;
      tbl_mask = t.mask; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!done && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk(n == 2 * (reads + writes) + 1, "R11 latency", n, 2 * (reads + writes) + 1);
      chk(res_hit === hit, "R1 R2 R3 hit", {31'h0, res_hit}, {31'h0, hit});
      chk(res_miss === !hit, "R9 miss", {31'h0, res_miss}, {31'h0, !hit});
      if (hit) begin
        chk(res_raddr === {t.rpn, t.ea[11:0]}, "R8 raddr", res_raddr, {t.rpn, t.ea[11:0]});
        chk(res_prot === t.exp_prot, "R7 prot", {29'h0, res_prot}, {29'h0, t.exp_prot});
        chk(rdw(w1_addr) === w1_exp, "R5 R6 status bytes", rdw(w1_addr), w1_exp);
      end
      chk(order_err == 0, "R4 word order", order_err, 0);
      @(negedge clk);
      // R9: ready again right after done
      chk(req_ready === 1'b1 && done === 1'b0, "R9 ready after done",
          {30'h0, req_ready, done}, 32'd2);
    end
    finish_run();
  end
endmodule